// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Generator

This block produces the external bus activity for a single machine cycle of an 8-bit processor. The processor shares its low address byte and its data byte on one set of lines. A cycle request carries a type code, a 16-bit address and, for writes, a data byte. The block accepts it while idle and steps through the T states of that cycle. In each T state it drives the latch-enable pulse, the two status bits, the memory/IO select, the three active-low strobes (read, write, interrupt acknowledge), the high address byte and the shared low lines. It captures the byte returned by a read and pulses `done` in the final T state.

Opcode fetches and interrupt acknowledges take four T states. When `long_fetch` is set they take six; this covers a fetch of a subroutine-call opcode or the acknowledge of a restart. Memory and I/O transfers always take three T states. Between cycles the bus is quiet and the shared lines are released.

Top module: `muxbus_cycle_gen`

## Requirements
- R1: After reset and while idle: `busy`=0, `done`=0, `ale`=0, `ad_oe`=0, `rd_n`=`wr_n`=`inta_n`=1, `{s1,s0}`=00, `io_m`=0, `a_hi`=0, `rdata`=0.
- R2: Type codes are 0 fetch, 1 mem read, 2 mem write, 3 IO read, 4 IO write, 5 int ack. A cycle starts one clock after `start` is sampled while idle. Types 1-4 last 3 T states. Types 0 and 5 last 4 T states, or 6 when `long_fetch`=1. `done` is high in the last T state only, and the block is idle in the next clock.
- R3: `ale` is high in T1 only. In T1, `ad_oe`=1 and `ad_out` holds address bits 7:0. `a_hi` holds address bits 15:8 in every T state of the cycle.
- R4: `{s1,s0}` is 11 for types 0 and 5, 10 for types 1 and 3, and 01 for types 2 and 4, for the whole cycle.
- R5: `io_m` is 1 for types 3, 4 and 5 and 0 for types 0, 1 and 2, for the whole cycle.
- R6: In T2 and T3 only, `rd_n` is low for types 0, 1 and 3, `wr_n` is low for types 2 and 4, and `inta_n` is low for type 5. At most one strobe is low at any time.
- R7: In write cycles, `ad_oe`=1 and `ad_out` carries the write byte in T2 and T3. In every other T state after T1, `ad_oe`=0.
- R8: For types 0, 1, 3 and 5, `ad_in` is captured into `rdata` at the end of T3. `rdata` keeps its value through write cycles and idle time.
- R9: `start` is ignored while a cycle is in progress. A request with type code 6 or 7 is ignored and the block stays idle.
- R10: `long_fetch` has no effect on types 1 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a cycle (sampled while idle) |
| cyc_type | input | 3 | Cycle type code |
| long_fetch | input | 1 | Stretch fetch / acknowledge to six T states |
| addr | input | 16 | Cycle address |
| wdata | input | 8 | Write byte |
| ad_in | input | 8 | Byte read from the shared low lines |
| ad_out | output | 8 | Byte driven on the shared low lines |
| ad_oe | output | 1 | Drive enable for the shared low lines |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| io_m | output | 1 | High for I/O and acknowledge cycles |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| rdata | output | 8 | Last captured read byte |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | Last T state of the cycle |

## Verification
The assertions assume that `start`, `cyc_type`, `long_fetch` and `addr` are clean, synchronous signals. They assume the request inputs are meaningful only in the clock where `start` is seen while idle. They also assume `ad_in` has settled by the T3 edge. The stimulus keeps to this by changing every input on the falling edge. It presents `ad_in` before T3 ends and lowers `start` one clock after a request. Only two deliberate exceptions break this pattern: a second request raised in the middle of a cycle, and requests with unsupported codes.

// File: rtl/muxbus_cycle_gen.sv
module muxbus_cycle_gen #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cyc_type,
  input  logic          long_fetch,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [AW-DW-1:0] a_hi,
  output logic          ale,
  output logic          s1,
  output logic          s0,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n,
  output logic          inta_n,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done
);
  localparam logic [2:0] OPF = 3'd0, MRD = 3'd1, MWR = 3'd2,
                         IORD = 3'd3, IOWR = 3'd4, IACK = 3'd5;

  logic [2:0]    t;
  logic [2:0]    typ;
  logic          lng;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic [DW-1:0] rd_q;

  wire req_ok   = cyc_type <= IACK;
  wire req_fch  = (cyc_type == OPF) || (cyc_type == IACK);
  wire is_fch   = (typ == OPF) || (typ == IACK);
  wire is_wr    = (typ == MWR) || (typ == IOWR);
  wire is_rdstb = (typ == OPF) || (typ == MRD) || (typ == IORD);
  wire is_io    = (typ == IORD) || (typ == IOWR) || (typ == IACK);
  wire [2:0] last = is_fch ? (lng ? 3'd6 : 3'd4) : 3'd3;
  wire act  = t != 3'd0;
  wire mid  = (t == 3'd2) || (t == 3'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t      <= 3'd0;
      typ    <= OPF;
      lng    <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else if (!act) begin
      if (start && req_ok) begin
        t      <= 3'd1;
        typ    <= cyc_type;
        lng    <= long_fetch && req_fch;
        addr_q <= addr;
        wd_q   <= wdata;
      end
    end else if (t == last) begin
      t <= 3'd0;
    end else begin
      t <= t + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_q <= '0;
    else if (t == 3'd3 && !is_wr)
      rd_q <= ad_in;
  end

  assign busy   = act;
  assign done   = act && (t == last);
  assign ale    = t == 3'd1;
  assign ad_oe  = (t == 3'd1) || (is_wr && mid);
  assign ad_out = (t == 3'd1) ? addr_q[DW-1:0] : (ad_oe ? wd_q : '0);
  assign a_hi   = act ? addr_q[AW-1:DW] : '0;
  assign s1     = act && !is_wr;
  assign s0     = act && (is_wr || is_fch);
  assign io_m   = act && is_io;
  assign rd_n   = !(mid && is_rdstb);
  assign wr_n   = !(mid && is_wr);
  assign inta_n = !(mid && (typ == IACK));
  assign rdata  = rd_q;
endmodule

// File: rtl/muxbus_cycle_gen_chk.sv
module muxbus_cycle_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       ale,
  input logic       ad_oe,
  input logic       rd_n,
  input logic       wr_n,
  input logic       inta_n,
  input logic [7:0] a_hi,
  input logic       s1,
  input logic       s0
);
  a_r3_ale_one_state: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r3_cycle_opens_with_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ale);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n, !inta_n}) <= 1);
  a_r7_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
  a_r7_read_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !inta_n) |-> !ad_oe);
  a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r3_high_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> $stable(a_hi));
  a_r4_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> ($stable(s1) && $stable(s0)));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_n && wr_n && inta_n && !ad_oe && !s1 && !s0));
endmodule

bind muxbus_cycle_gen muxbus_cycle_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .ale(ale),
  .ad_oe(ad_oe), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
  .a_hi(a_hi), .s1(s1), .s0(s0)
);

// File: tb/muxbus_cycle_gen_test.sv
module muxbus_cycle_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;
  // {type[3], long[1], addr[16], wdata[8], bus byte[8]}
  localparam logic [35:0] VEC [NV] = '{
    {3'd0, 1'b0, 16'h2034, 8'h00, 8'h3E},
    {3'd1, 1'b0, 16'h2050, 8'h00, 8'h45},
    {3'd2, 1'b0, 16'h20FF, 8'hA5, 8'h77},
    {3'd3, 1'b0, 16'h0081, 8'h00, 8'h5A},
    {3'd4, 1'b0, 16'h0082, 8'hC3, 8'h99},
    {3'd5, 1'b0, 16'h1234, 8'h00, 8'hCF},
    {3'd0, 1'b1, 16'h0000, 8'h00, 8'hCD},
    {3'd5, 1'b1, 16'hFFFF, 8'h00, 8'hFF},
    {3'd1, 1'b1, 16'h8001, 8'h00, 8'h11}
  };

  logic clk = 0, rst_n = 0, start = 0, long_fetch = 0;
  logic [2:0] cyc_type = 0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, ad_in = 0;
  logic [7:0] ad_out, a_hi, rdata;
  logic ad_oe, ale, s1, s0, io_m, rd_n, wr_n, inta_n, busy, done;

  int checks = 0, failures = 0;
  logic [7:0] exp_rd = 0;
  bit finished = 0;

  muxbus_cycle_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cyc_type(cyc_type),
    .long_fetch(long_fetch), .addr(addr), .wdata(wdata), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .s1(s1), .s0(s0),
    .io_m(io_m), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rdata(rdata),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_chk();
    chk("R1 busy", busy, 0);   chk("R1 done", done, 0);
    chk("R1 ale", ale, 0);     chk("R1 ad_oe", ad_oe, 0);
    chk("R1 strobes", {rd_n, wr_n, inta_n}, 3'b111);
    chk("R1 status", {s1, s0}, 0); chk("R1 io_m", io_m, 0);
    chk("R1 a_hi", a_hi, 0);
  endtask

  task automatic run_cyc(input logic [2:0] ty, input logic lg,
                         input logic [15:0] a, input logic [7:0] wd,
                         input logic [7:0] bd);
    bit fch = (ty == 0) || (ty == 5);
    bit wr  = (ty == 2) || (ty == 4);
    bit rdl = (ty == 0) || (ty == 1) || (ty == 3);
    bit io  = (ty >= 3);
    int len = fch ? (lg ? 6 : 4) : 3;
    int st  = fch ? 3 : (wr ? 1 : 2);
    cyc_type = ty; long_fetch = lg; addr = a; wdata = wd; ad_in = bd; start = 1;
    @(negedge clk); start = 0;
    for (int n = 1; n <= len; n++) begin
      bit md = (n == 2) || (n == 3);
      chk("R2 busy", busy, 1);
      chk(lg && !fch ? "R10 done" : "R2 done", done, n == len);
      chk("R3 ale", ale, n == 1);
      chk("R3 a_hi", a_hi, a[15:8]);
      chk("R7 ad_oe", ad_oe, (n == 1) || (wr && md));
      if (n == 1) chk("R3 ad_out addr", ad_out, a[7:0]);
      if (wr && md) chk("R7 ad_out data", ad_out, wd);
      chk("R4 status", {s1, s0}, st);
      chk("R5 io_m", io_m, io);
      chk("R6 rd_n", rd_n, !(rdl && md));
      chk("R6 wr_n", wr_n, !(wr && md));
      chk("R6 inta_n", inta_n, !((ty == 5) && md));
      if (n < len) @(negedge clk);
    end
    @(negedge clk);
    if (!wr) exp_rd = bd;
    chk("R2 idle after", busy, 0);
    chk("R8 rdata", rdata, exp_rd);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk();
    chk("R1 rdata", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    idle_chk();

    for (int i = 0; i < NV; i++)
      run_cyc(VEC[i][35:33], VEC[i][32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // R9: unsupported codes are ignored
    for (int c = 6; c < 8; c++) begin
      cyc_type = 3'(c); start = 1; ad_in = 8'hEE;
      @(negedge clk); start = 0;
      @(negedge clk);
      chk("R9 bad code busy", busy, 0);
      chk("R9 bad code ale", ale, 0);
      chk("R9 bad code rdata", rdata, exp_rd);
    end

    // R9: second request during a cycle is ignored
    cyc_type = 3'd1; long_fetch = 0; addr = 16'h4321; ad_in = 8'h6B; start = 1;
    @(negedge clk);
    cyc_type = 3'd2; addr = 16'h9999; wdata = 8'h11;
    @(negedge clk); start = 0;
    chk("R9 strobe kept read", {rd_n, wr_n}, 2'b01);
    chk("R9 a_hi kept", a_hi, 8'h43);
    @(negedge clk);
    chk("R9 done at T3", done, 1);
    @(negedge clk);
    exp_rd = 8'h6B;
    chk("R9 idle after", busy, 0);
    chk("R9 rdata", rdata, exp_rd);

    // R8: writes leave captured data alone
    run_cyc(3'd4, 1'b1, 16'h00F0, 8'h3C, 8'h00);
    chk("R8 rdata after write", rdata, 8'h6B);

    // R1: reset in the middle of a fetch
    cyc_type = 3'd0; addr = 16'hABCD; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk);
    rst_n = 0;
    #1;
    idle_chk();
    chk("R1 rdata reset", rdata, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    idle_chk();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    finished = 1;
    $finish;
  end
endmodule